// File: doc/BRIEF.md
# Custom Add Coprocessor

This unit sits beside a processor core on an instruction-offload port. For every offered 32-bit instruction it answers in the same cycle. The answer says whether the instruction belongs to the unit, whether it will write a destination register, and which of the three source operands (rs1, rs2, rs3) the core must actually supply. Accepted instructions add their operands. The sum comes back on a result port together with the destination register index, the instruction id, the hart id and a write-enable. A separate stateless path turns two 16-bit compressed encodings into their 32-bit equivalents so the core can offer them on the main port.

Two timings exist. Ordinary adds return in the cycle after the issue handshake. One add variant is multicycle. While it is in flight the unit drops its issue-ready, so results always leave in issue order. The datapath width is the parameter `XLEN`. All sums wrap modulo 2^XLEN and nothing reports a carry out.

Top module: `xadd_copro`

## Requirements
- R1: The word 0x0000007B (major opcode 0x7B, bits [31:7] all zero) is accepted as a no-op. It reads no operand, has writeback low, and produces one result with write-enable low and data zero.
- R2: Under opcode 0x7B with bits [14:12] = 001, the value in bits [31:25] selects the operation. 0 gives rs1+rs2 and reads flags 011. 1 gives rs1+rs1 and reads flags 001. 2 gives rs2+rs2 and reads flags 010. 3 gives rs1+rs2 and reads flags 011. Each writes the register in bits [11:7]. The read flags are written as {rs3,rs2,rs1}.
- R3: Opcodes 0x43, 0x47, 0x4B and 0x4F are accepted when bits [26:25] = 00 and bits [14:12] = 000. Such a word computes rs1+rs2+rs3 into the register in bits [11:7] and reads flags 111.
- R4: Opcode 0x43 with bits [31:25] = 0000100 and bits [14:12] = 001 computes rs1+rs2+rs3. Its rs3 index sits in bits [11:7]. It reads flags 111 and always writes register 10.
- R5: Every other word is refused. The unit gives accept, writeback and read flags all zero and never produces a result for it.
- R6: A compressed word with bits [15:13] = 111 and bits [1:0] = 00 is accepted. With bit 12 = 0 it expands to 0x0000007B. With bit 12 = 1 it expands to the R2 funct7=0 add: rs1 is taken from bits [11:7], rs2 from bits [6:2], and rd is 10. Any other compressed word is refused and its expansion is zero.
- R7: A single-cycle result is valid in the cycle right after the issue handshake. It echoes that instruction's id, hart id and destination register. Back-to-back issues return in issue order.
- R8: The multicycle add (R2, funct7 = 3) returns its result 4 cycles after the handshake cycle. Issue-ready stays low from the cycle after the handshake until the result appears.
- R9: Sums wrap modulo 2^XLEN.
- R10: After reset no result is valid and issue-ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Instruction offered |
| iss_instr | input | 32 | Offered instruction word |
| iss_id | input | IDW | Instruction id |
| iss_hart | input | HARTW | Hart id |
| iss_ops | input | NR_RS*XLEN | Source operands, rs1 in the low slice |
| iss_ready | output | 1 | Unit can take an instruction |
| iss_accept | output | 1 | Offered word belongs to the unit |
| iss_writeback | output | 1 | Accepted word writes a register |
| iss_rdread | output | 3 | Operands consumed, {rs3,rs2,rs1} |
| cmp_valid | input | 1 | Compressed word offered |
| cmp_instr | input | 16 | Compressed word |
| cmp_accept | output | 1 | Compressed word recognised |
| cmp_instr_out | output | 32 | Expanded instruction |
| res_valid | output | 1 | Result valid (one-cycle pulse) |
| res_data | output | XLEN | Sum |
| res_id | output | IDW | Echoed id |
| res_hart | output | HARTW | Echoed hart id |
| res_rd | output | 5 | Destination register |
| res_we | output | 1 | Register write enable |

## Verification
The bench targets decode near-misses: a 0x7B word with funct3 010, funct7 values just past 3, fused-add words with bits [26:25] = 01, and funct3 001 on the other fused-add opcodes. A decoder that is too loose would accept these and emit a result the scoreboard never expected. The multicycle add is timed exactly, and the bench probes issue-ready in the cycle after it. A wrong counter would show up as an early or late result, or as a stray handshake that breaks ordering. Operand-swap cases (rs1+rs1 against rs2+rs2), carry wrap-around, and the fixed register 10 of the R4 form and the compressed add catch operand-select and rd-override errors.

// File: rtl/xadd_pkg.sv
package xadd_pkg;

   typedef enum logic [2:0] {
      K_NOP  = 3'd0,
      K_ADD  = 3'd1,
      K_DBL1 = 3'd2,
      K_DBL2 = 3'd3,
      K_ADD3 = 3'd4
   } kind_e;

   typedef struct packed {
      logic       accept;
      logic       we;
      logic       multi;
      logic [2:0] rread;
      kind_e      kind;
      logic [4:0] rd;
   } dec_t;

   localparam logic [6:0] OPC_CUSTOM = 7'h7B;
   localparam logic [6:0] OPC_FMA0   = 7'h43;
   localparam logic [6:0] OPC_FMA1   = 7'h47;
   localparam logic [6:0] OPC_FMA2   = 7'h4B;
   localparam logic [6:0] OPC_FMA3   = 7'h4F;
   localparam logic [4:0] RD_FIXED   = 5'd10;

endpackage

// File: rtl/xadd_decode.sv
module xadd_decode
   import xadd_pkg::*;
#(
   parameter bit HAS_RS3 = 1'b1
) (
   input  logic [31:0] instr,
   output dec_t        dec
);

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;
   logic       fma_opc;
   logic       rs3_ok;

   assign opc = instr[6:0];
   assign f3  = instr[14:12];
   assign f7  = instr[31:25];
   assign fma_opc = (opc == OPC_FMA0) || (opc == OPC_FMA1) ||
                    (opc == OPC_FMA2) || (opc == OPC_FMA3);

   generate
      if (HAS_RS3) begin : g_rs3
         assign rs3_ok = 1'b1;
      end else begin : g_no_rs3
         assign rs3_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      dec = '0;
      dec.kind = K_NOP;
      dec.rd = instr[11:7];
      if (opc == OPC_CUSTOM && instr[31:7] == 25'd0) begin
         dec.accept = 1'b1;
         dec.rd     = 5'd0;
      end else if (opc == OPC_CUSTOM && f3 == 3'b001) begin
         unique case (f7)
            7'd0: begin dec.accept = 1'b1; dec.kind = K_ADD;  dec.rread = 3'b011; end
            7'd1: begin dec.accept = 1'b1; dec.kind = K_DBL1; dec.rread = 3'b001; end
            7'd2: begin dec.accept = 1'b1; dec.kind = K_DBL2; dec.rread = 3'b010; end
            7'd3: begin dec.accept = 1'b1; dec.kind = K_ADD;  dec.rread = 3'b011;
                        dec.multi = 1'b1; end
            default: ;
         endcase
         dec.we = dec.accept;
      end else if (rs3_ok && fma_opc && instr[26:25] == 2'b00 && f3 == 3'b000) begin
         dec.accept = 1'b1;
         dec.we     = 1'b1;
         dec.kind   = K_ADD3;
         dec.rread  = 3'b111;
      end else if (rs3_ok && opc == OPC_FMA0 && f7 == 7'b0000100 && f3 == 3'b001) begin
         dec.accept = 1'b1;
         dec.we     = 1'b1;
         dec.kind   = K_ADD3;
         dec.rread  = 3'b111;
         dec.rd     = RD_FIXED;
      end
      if (!dec.accept) begin
         dec.rd = 5'd0;
      end
   end

endmodule

// File: rtl/xadd_cexpand.sv
module xadd_cexpand
   import xadd_pkg::*;
(
   input  logic [15:0] cword,
   output logic        accept,
   output logic [31:0] xword
);

   logic hit;
   assign hit = (cword[15:13] == 3'b111) && (cword[1:0] == 2'b00);

   always_comb begin
      accept = hit;
      xword  = 32'd0;
      if (hit) begin
         if (cword[12]) begin
            xword = {7'd0, cword[6:2], cword[11:7], 3'b001, RD_FIXED, OPC_CUSTOM};
         end else begin
            xword = {25'd0, OPC_CUSTOM};
         end
      end
   end

endmodule

// File: rtl/xadd_exec.sv
module xadd_exec
   import xadd_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned NR_RS  = 3,
   parameter int unsigned IDW    = 4,
   parameter int unsigned HARTW  = 2,
   parameter int unsigned MC_LAT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fire,
   input  dec_t                  dec,
   input  logic [NR_RS*XLEN-1:0] ops,
   input  logic [IDW-1:0]        id,
   input  logic [HARTW-1:0]      hart,
   output logic                  busy,
   output logic                  out_valid,
   output logic [XLEN-1:0]       out_data,
   output logic [IDW-1:0]        out_id,
   output logic [HARTW-1:0]      out_hart,
   output logic [4:0]            out_rd,
   output logic                  out_we
);

   localparam int unsigned CW = $clog2(MC_LAT + 1);
   localparam logic [CW-1:0] CNT_LOAD = CW'(MC_LAT - 1);

   logic [XLEN-1:0] r1, r2, r3, sum;

   assign r1 = ops[XLEN-1:0];
   assign r2 = ops[2*XLEN-1:XLEN];

   generate
      if (NR_RS >= 3) begin : g_op3
         assign r3 = ops[3*XLEN-1:2*XLEN];
      end else begin : g_op2
         assign r3 = '0;
      end
   endgenerate

   always_comb begin
      unique case (dec.kind)
         K_ADD:   sum = r1 + r2;
         K_DBL1:  sum = r1 + r1;
         K_DBL2:  sum = r2 + r2;
         K_ADD3:  sum = r1 + r2 + r3;
         default: sum = '0;
      endcase
   end

   logic [CW-1:0]    cnt_q;
   logic [XLEN-1:0]  p_data;
   logic [IDW-1:0]   p_id;
   logic [HARTW-1:0] p_hart;
   logic [4:0]       p_rd;
   logic             p_we;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         p_data    <= '0;
         p_id      <= '0;
         p_hart    <= '0;
         p_rd      <= '0;
         p_we      <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_id    <= '0;
         out_hart  <= '0;
         out_rd    <= '0;
         out_we    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (fire && !dec.multi) begin
            out_valid <= 1'b1;
            out_data  <= sum;
            out_id    <= id;
            out_hart  <= hart;
            out_rd    <= dec.rd;
            out_we    <= dec.we;
         end
         if (fire && dec.multi) begin
            cnt_q  <= CNT_LOAD;
            p_data <= sum;
            p_id   <= id;
            p_hart <= hart;
            p_rd   <= dec.rd;
            p_we   <= dec.we;
         end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               out_valid <= 1'b1;
               out_data  <= p_data;
               out_id    <= p_id;
               out_hart  <= p_hart;
               out_rd    <= p_rd;
               out_we    <= p_we;
            end
         end
      end
   end

   p_busy_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fire) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/xadd_copro.sv
module xadd_copro
   import xadd_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned NR_RS  = 3,
   parameter int unsigned IDW    = 4,
   parameter int unsigned HARTW  = 2,
   parameter int unsigned MC_LAT = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  iss_valid,
   input  logic [31:0]           iss_instr,
   input  logic [IDW-1:0]        iss_id,
   input  logic [HARTW-1:0]      iss_hart,
   input  logic [NR_RS*XLEN-1:0] iss_ops,
   output logic                  iss_ready,
   output logic                  iss_accept,
   output logic                  iss_writeback,
   output logic [2:0]            iss_rdread,
   input  logic                  cmp_valid,
   input  logic [15:0]           cmp_instr,
   output logic                  cmp_accept,
   output logic [31:0]           cmp_instr_out,
   output logic                  res_valid,
   output logic [XLEN-1:0]       res_data,
   output logic [IDW-1:0]        res_id,
   output logic [HARTW-1:0]      res_hart,
   output logic [4:0]            res_rd,
   output logic                  res_we
);

   localparam bit HAS_RS3 = (NR_RS >= 3);

   generate
      if (NR_RS < 2 || NR_RS > 3) begin : g_bad_nr
         $error("xadd_copro: NR_RS must be 2 or 3");
      end
      if (MC_LAT < 2) begin : g_bad_lat
         $error("xadd_copro: MC_LAT must be at least 2");
      end
      if (XLEN < 8) begin : g_bad_xlen
         $error("xadd_copro: XLEN too small");
      end
   endgenerate

   dec_t dec;
   logic busy;
   logic fire;
   logic c_hit;

   xadd_decode #(.HAS_RS3(HAS_RS3)) u_dec (
      .instr (iss_instr),
      .dec   (dec)
   );

   xadd_cexpand u_cexp (
      .cword  (cmp_instr),
      .accept (c_hit),
      .xword  (cmp_instr_out)
   );

   assign cmp_accept = cmp_valid && c_hit;

   assign iss_ready     = !busy;
   assign iss_accept    = iss_valid && dec.accept;
   assign iss_writeback = iss_valid && dec.we;
   assign iss_rdread    = iss_valid ? dec.rread : 3'b000;
   assign fire          = iss_valid && iss_ready && dec.accept;

   xadd_exec #(
      .XLEN(XLEN), .NR_RS(NR_RS), .IDW(IDW), .HARTW(HARTW), .MC_LAT(MC_LAT)
   ) u_exec (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (fire),
      .dec       (dec),
      .ops       (iss_ops),
      .id        (iss_id),
      .hart      (iss_hart),
      .busy      (busy),
      .out_valid (res_valid),
      .out_data  (res_data),
      .out_id    (res_id),
      .out_hart  (res_hart),
      .out_rd    (res_rd),
      .out_we    (res_we)
   );

   p_single_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !dec.multi) |=> (res_valid && res_id == $past(iss_id) &&
                                res_hart == $past(iss_hart)));

   p_multi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && dec.multi) |=> (!iss_ready && !res_valid));

   p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_ready && !iss_accept) |=> !res_valid);

   p_nop_reads_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_accept && !iss_writeback) |-> (iss_rdread == 3'b000));

   p_cexp_custom_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_accept |-> (cmp_instr_out[6:0] == OPC_CUSTOM));

   p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!res_valid && iss_ready));

endmodule

// File: tb/xadd_copro_tb.sv
`timescale 1ns/1ps
module xadd_copro_tb;

   localparam int XLEN = 32;
   localparam int NR_RS = 3;
   localparam int IDW = 4;
   localparam int HARTW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_valid = 1'b0;
   logic [31:0] iss_instr = '0;
   logic [IDW-1:0] iss_id = '0;
   logic [HARTW-1:0] iss_hart = '0;
   logic [NR_RS*XLEN-1:0] iss_ops = '0;
   logic iss_ready, iss_accept, iss_writeback;
   logic [2:0] iss_rdread;
   logic cmp_valid = 1'b0;
   logic [15:0] cmp_instr = '0;
   logic cmp_accept;
   logic [31:0] cmp_instr_out;
   logic res_valid;
   logic [XLEN-1:0] res_data;
   logic [IDW-1:0] res_id;
   logic [HARTW-1:0] res_hart;
   logic [4:0] res_rd;
   logic res_we;

   always #10 clk = ~clk;

   xadd_copro u_dut (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_instr(iss_instr), .iss_id(iss_id),
      .iss_hart(iss_hart), .iss_ops(iss_ops), .iss_ready(iss_ready),
      .iss_accept(iss_accept), .iss_writeback(iss_writeback),
      .iss_rdread(iss_rdread), .cmp_valid(cmp_valid), .cmp_instr(cmp_instr),
      .cmp_accept(cmp_accept), .cmp_instr_out(cmp_instr_out),
      .res_valid(res_valid), .res_data(res_data), .res_id(res_id),
      .res_hart(res_hart), .res_rd(res_rd), .res_we(res_we)
   );

   typedef struct {
      logic [XLEN-1:0]  data;
      logic [IDW-1:0]   id;
      logic [HARTW-1:0] hart;
      logic [4:0]       rd;
      logic             we;
      int               cyc;
      string            req;
   } exp_t;

   exp_t sb[$];
   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   logic [IDW-1:0] next_id = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
      end
   endtask

   // monitor: pops the scoreboard as results emerge
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R5", "unexpected result", res_data, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(res_data == e.data, e.req, "data", res_data, e.data);
            check(res_id == e.id && res_hart == e.hart, "R7", "id/hart",
                  {res_hart, res_id}, {e.hart, e.id});
            check(res_rd == e.rd && res_we == e.we, e.req, "rd/we",
                  {res_rd, res_we}, {e.rd, e.we});
            check(cyc == e.cyc, (e.cyc - 0 > 0) ? e.req : e.req, "latency cycle",
                  cyc, e.cyc);
         end
      end
   end

   // driver
   task automatic issue(input logic [31:0] w, input logic [XLEN-1:0] a,
                        input logic [XLEN-1:0] b, input logic [XLEN-1:0] c,
                        input bit acc, input bit we, input logic [2:0] rr,
                        input logic [4:0] rd, input logic [XLEN-1:0] sum,
                        input bit multi, input string req);
      exp_t e;
      @(negedge clk);
      while (!iss_ready) @(negedge clk);
      iss_valid = 1'b1;
      iss_instr = w;
      iss_ops   = {c, b, a};
      iss_id    = next_id;
      iss_hart  = next_id[HARTW-1:0] ^ 2'b01;
      #1;
      check(iss_accept == acc, req, "accept", iss_accept, acc);
      check(iss_writeback == we, req, "writeback", iss_writeback, we);
      check(iss_rdread == rr, req, "read flags", iss_rdread, rr);
      if (acc) begin
         e.data = sum; e.id = iss_id; e.hart = iss_hart; e.rd = rd; e.we = we;
         e.cyc = cyc + (multi ? 4 : 1);
         e.req = req;
         sb.push_back(e);
      end
      next_id = next_id + 1'b1;
      @(posedge clk);
      #1;
      iss_valid = 1'b0;
   endtask

   function automatic logic [31:0] r2w(input logic [6:0] f7, input logic [4:0] s2,
                                       input logic [4:0] s1, input logic [2:0] f3,
                                       input logic [4:0] d, input logic [6:0] op);
      return {f7, s2, s1, f3, d, op};
   endfunction

   task automatic ccheck(input logic [15:0] cw, input bit acc, input logic [31:0] xw);
      @(negedge clk);
      cmp_valid = 1'b1;
      cmp_instr = cw;
      #1;
      check(cmp_accept == acc, "R6", "c accept", cmp_accept, acc);
      check(cmp_instr_out == xw, "R6", "c expansion", cmp_instr_out, xw);
      cmp_valid = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(res_valid == 1'b0, "R10", "res_valid in reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_valid == 1'b0 && iss_ready == 1'b1, "R10", "idle after reset",
            {res_valid, iss_ready}, 2'b01);

      // R1 no-op
      issue(32'h0000007B, 1, 2, 3, 1, 0, 3'b000, 5'd0, 0, 0, "R1");
      // R2 variants
      issue(r2w(7'd0, 5'd2, 5'd1, 3'b001, 5'd5, 7'h7B), 10, 20, 99, 1, 1, 3'b011, 5'd5, 30, 0, "R2");
      issue(r2w(7'd1, 5'd2, 5'd1, 3'b001, 5'd6, 7'h7B), 7, 100, 99, 1, 1, 3'b001, 5'd6, 14, 0, "R2");
      issue(r2w(7'd2, 5'd2, 5'd1, 3'b001, 5'd7, 7'h7B), 100, 9, 99, 1, 1, 3'b010, 5'd7, 18, 0, "R2");
      // R8 multicycle
      issue(r2w(7'd3, 5'd2, 5'd1, 3'b001, 5'd8, 7'h7B), 40, 2, 99, 1, 1, 3'b011, 5'd8, 42, 1, "R8");
      @(negedge clk);
      check(iss_ready == 1'b0, "R8", "ready low while multicycle", iss_ready, 0);
      // R7 back-to-back after multi
      issue(r2w(7'd0, 5'd3, 5'd4, 3'b001, 5'd9, 7'h7B), 1, 1, 0, 1, 1, 3'b011, 5'd9, 2, 0, "R7");
      issue(r2w(7'd0, 5'd3, 5'd4, 3'b001, 5'd11, 7'h7B), 5, 6, 0, 1, 1, 3'b011, 5'd11, 11, 0, "R7");
      // R3 on the four fused opcodes
      issue({5'd3, 2'b00, 5'd2, 5'd1, 3'b000, 5'd12, 7'h43}, 1, 2, 4, 1, 1, 3'b111, 5'd12, 7, 0, "R3");
      issue({5'd3, 2'b00, 5'd2, 5'd1, 3'b000, 5'd13, 7'h47}, 10, 20, 30, 1, 1, 3'b111, 5'd13, 60, 0, "R3");
      issue({5'd3, 2'b00, 5'd2, 5'd1, 3'b000, 5'd14, 7'h4B}, 3, 3, 3, 1, 1, 3'b111, 5'd14, 9, 0, "R3");
      issue({5'd3, 2'b00, 5'd2, 5'd1, 3'b000, 5'd15, 7'h4F}, 100, 0, 1, 1, 1, 3'b111, 5'd15, 101, 0, "R3");
      // R4 fixed destination
      issue(r2w(7'b0000100, 5'd2, 5'd1, 3'b001, 5'd20, 7'h43), 5, 6, 7, 1, 1, 3'b111, 5'd10, 18, 0, "R4");
      // R5 near-misses
      issue(r2w(7'd0, 5'd2, 5'd1, 3'b010, 5'd5, 7'h7B), 1, 1, 1, 0, 0, 3'b000, 0, 0, 0, "R5");
      issue(r2w(7'd4, 5'd2, 5'd1, 3'b001, 5'd5, 7'h7B), 1, 1, 1, 0, 0, 3'b000, 0, 0, 0, "R5");
      issue({5'd3, 2'b01, 5'd2, 5'd1, 3'b000, 5'd5, 7'h43}, 1, 1, 1, 0, 0, 3'b000, 0, 0, 0, "R5");
      issue(r2w(7'b0000100, 5'd2, 5'd1, 3'b001, 5'd5, 7'h47), 1, 1, 1, 0, 0, 3'b000, 0, 0, 0, "R5");
      issue(32'h00000033, 1, 1, 1, 0, 0, 3'b000, 0, 0, 0, "R5");
      // R9 wrap
      issue(r2w(7'd0, 5'd2, 5'd1, 3'b001, 5'd5, 7'h7B), 32'hFFFF_FFFF, 2, 0, 1, 1, 3'b011, 5'd5, 1, 0, "R9");
      issue({5'd3, 2'b00, 5'd2, 5'd1, 3'b000, 5'd6, 7'h4F}, 32'h8000_0000, 32'h8000_0000, 5, 1, 1, 3'b111, 5'd6, 5, 0, "R9");
      issue(r2w(7'd3, 5'd2, 5'd1, 3'b001, 5'd8, 7'h7B), 32'hFFFF_FFF0, 32'h20, 0, 1, 1, 3'b011, 5'd8, 32'h10, 1, "R9");
      // R6 compressed
      ccheck(16'hE000, 1, 32'h0000007B);
      ccheck({3'b111, 1'b1, 5'd9, 5'd17, 2'b00}, 1,
             {7'd0, 5'd17, 5'd9, 3'b001, 5'd10, 7'h7B});
      ccheck(16'hE001, 0, 32'd0);
      ccheck(16'h6000, 0, 32'd0);

      repeat (8) @(negedge clk);
      check(sb.size() == 0, "R7", "all results returned", sb.size(), 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule